// File: doc/BRIEF.md
# Dual-Issue Memory/Integer Pairing Gate

This block sits between decode and execute in an in-order pipeline that can start at most two instructions per cycle. Each cycle it looks at the two oldest decoded instructions waiting at the head of the issue window. It decides whether the older one may enter execute, and whether the younger one may enter execute alongside it. The two execute lanes are fixed. Lane 0 takes only a load or a store, and lane 1 takes only an integer ALU operation. So a pair can form only when a memory operation is followed by an integer operation, and only after a hardware check shows that the two are independent. An older instruction of any other kind goes alone.

The block also receives the destination register of the instruction now in execute, and a flag that marks it as a load. From these it applies the classic one-cycle load-use bubble. The decision is purely combinational and is valid in the same cycle as its inputs. The surrounding pipeline acts on it at the next clock edge.

The two grant outputs act as the per-slot ready signals for the two valid inputs. An instruction is consumed only in a cycle where its valid and its grant are both high. When only the older instruction is granted, the younger one moves to the head of the window on the next cycle. The block never grants the younger instruction without the older one, so issue stays in program order.

Top module: `dual_issue_pair_gate`

## Requirements
- R1: `go_yng` is never high unless `go_old` is high in the same cycle.
- R2: A pair is granted only when the older class is LOAD (2'b01) or STORE (2'b10) and the younger class is ALU (2'b00). Any other class combination holds the younger instruction back.
- R3: If the older instruction writes a nonzero register (`old_wr`=1) that either source of the younger instruction names, the younger instruction is held back.
- R4: If both instructions write the same nonzero register, the younger instruction is held back.
- R5: Register 0 never creates a dependence, whether it appears as a source or as a destination. A destination whose write enable is low is also ignored.
- R6: If `ex_is_load`=1 and `ex_dst` is nonzero and either source of the older instruction equals it, both grants are low.
- R7: If either source of the younger instruction equals a nonzero `ex_dst` while `ex_is_load`=1, the younger instruction is held back, and the older one may still go.
- R8: An older instruction of class ALU (2'b00) or OTHER (2'b11) that is free of any load-use hazard is granted alone.
- R9: An invalid older slot gives both grants low. An invalid younger slot gives `go_yng` low.
- R10: `stall` is high exactly when the older slot is valid and `go_old` is low.
- R11: A valid memory/ALU pair with no hazard of R3 to R7 is granted both lanes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| old_valid | input | 1 | Older (head) instruction present |
| old_cls | input | 2 | Older class: 00 ALU, 01 LOAD, 10 STORE, 11 OTHER |
| old_src_a | input | REG_W | Older first source register |
| old_src_b | input | REG_W | Older second source register |
| old_dst | input | REG_W | Older destination register |
| old_wr | input | 1 | Older writes its destination |
| yng_valid | input | 1 | Younger instruction present |
| yng_cls | input | 2 | Younger class, same encoding |
| yng_src_a | input | REG_W | Younger first source register |
| yng_src_b | input | REG_W | Younger second source register |
| yng_dst | input | REG_W | Younger destination register |
| yng_wr | input | 1 | Younger writes its destination |
| ex_dst | input | REG_W | Destination of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| go_old | output | 1 | Older instruction enters execute this cycle |
| go_yng | output | 1 | Younger instruction enters execute this cycle |
| stall | output | 1 | Valid older instruction is held |

## Verification
All three outputs are due in the same cycle as the inputs that cause them, because no register lies between the instruction fields and the grants. The bench therefore changes inputs just after a rising edge and samples at the following falling edge, with no latency offset. During sequence replay, the bench's own model of the issue window and of the execute stage advances at each rising edge. It then feeds the next cycle's execute-stage load flag and destination back into the block. So the one-cycle load-use bubble shows up as a start-of-execute cycle that is one later than it would otherwise be. These start cycles are compared with values worked out by hand.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_OTHER = 2'b11
  } icls_e;

  function automatic logic cls_is_mem(input logic [CLS_W-1:0] c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction

  function automatic logic cls_is_alu(input logic [CLS_W-1:0] c);
    return c == CLS_ALU;
  endfunction
endpackage

// File: rtl/dip_src_hit.sv
module dip_src_hit #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC*REG_W-1:0] srcs,
  input  logic [REG_W-1:0]      dst,
  input  logic                  dst_live,
  output logic                  hit
);
  logic [NSRC-1:0] per_src;
  logic            dst_real;

  assign dst_real = dst_live && (dst != '0);

  for (genvar k = 0; k < NSRC; k++) begin : g_cmp
    assign per_src[k] = dst_real && (srcs[k*REG_W +: REG_W] == dst);
  end

  assign hit = |per_src;
endmodule

// File: rtl/dip_pair_rule.sv
module dip_pair_rule
  import dip_pkg::*;
(
  input  logic [CLS_W-1:0] old_cls,
  input  logic [CLS_W-1:0] yng_cls,
  output logic             shape_ok
);
  assign shape_ok = cls_is_mem(old_cls) && cls_is_alu(yng_cls);
endmodule

// File: rtl/dual_issue_pair_gate.sv
module dual_issue_pair_gate #(
  parameter int REG_W = 5
) (
  input  logic             old_valid,
  input  logic [1:0]       old_cls,
  input  logic [REG_W-1:0] old_src_a,
  input  logic [REG_W-1:0] old_src_b,
  input  logic [REG_W-1:0] old_dst,
  input  logic             old_wr,
  input  logic             yng_valid,
  input  logic [1:0]       yng_cls,
  input  logic [REG_W-1:0] yng_src_a,
  input  logic [REG_W-1:0] yng_src_b,
  input  logic [REG_W-1:0] yng_dst,
  input  logic             yng_wr,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_is_load,
  output logic             go_old,
  output logic             go_yng,
  output logic             stall
);
  localparam int NSRC = 2;

  logic old_lu, yng_lu, raw_hit, waw_hit, shape_ok;

  // older instruction against a load now in execute
  dip_src_hit #(.REG_W(REG_W), .NSRC(NSRC)) u_old_lu (
    .srcs({old_src_b, old_src_a}), .dst(ex_dst), .dst_live(ex_is_load), .hit(old_lu)
  );

  // younger instruction against a load now in execute
  dip_src_hit #(.REG_W(REG_W), .NSRC(NSRC)) u_yng_lu (
    .srcs({yng_src_b, yng_src_a}), .dst(ex_dst), .dst_live(ex_is_load), .hit(yng_lu)
  );

  // read-after-write inside the pair
  dip_src_hit #(.REG_W(REG_W), .NSRC(NSRC)) u_raw (
    .srcs({yng_src_b, yng_src_a}), .dst(old_dst), .dst_live(old_wr), .hit(raw_hit)
  );

  // write-after-write inside the pair
  dip_src_hit #(.REG_W(REG_W), .NSRC(1)) u_waw (
    .srcs(yng_dst), .dst(old_dst), .dst_live(old_wr && yng_wr), .hit(waw_hit)
  );

  dip_pair_rule u_shape (.old_cls(old_cls), .yng_cls(yng_cls), .shape_ok(shape_ok));

  logic old_ok, pair_ok;

  always_comb begin
    old_ok  = old_valid && !old_lu;
    pair_ok = yng_valid && shape_ok && !raw_hit && !waw_hit && !yng_lu;
    go_old  = old_ok;
    go_yng  = old_ok && pair_ok;
    stall   = old_valid && !old_ok;
  end
endmodule

// File: rtl/dip_gate_chk.sv
module dip_gate_chk #(
  parameter int REG_W = 5
) (
  input logic             old_valid,
  input logic [1:0]       old_cls,
  input logic [REG_W-1:0] old_src_a,
  input logic [REG_W-1:0] old_src_b,
  input logic [REG_W-1:0] old_dst,
  input logic             old_wr,
  input logic             yng_valid,
  input logic [1:0]       yng_cls,
  input logic [REG_W-1:0] yng_src_a,
  input logic [REG_W-1:0] yng_src_b,
  input logic [REG_W-1:0] yng_dst,
  input logic             yng_wr,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_is_load,
  input logic             go_old,
  input logic             go_yng,
  input logic             stall
);
  logic known;

  always_comb begin
    known = !$isunknown({old_valid, old_cls, old_src_a, old_src_b, old_dst, old_wr,
                         yng_valid, yng_cls, yng_src_a, yng_src_b, yng_dst, yng_wr,
                         ex_dst, ex_is_load, go_old, go_yng, stall});
    if (known) begin
      p_in_order_r1: assert (!go_yng || go_old)
        else $error("younger granted without older");
      p_pair_shape_r2: assert (!go_yng || ((old_cls == 2'b01 || old_cls == 2'b10) && yng_cls == 2'b00))
        else $error("pair granted with wrong classes");
      p_raw_block_r3: assert (!(go_yng && old_wr && old_dst != '0 &&
                                (yng_src_a == old_dst || yng_src_b == old_dst)))
        else $error("pair granted across RAW");
      p_waw_block_r4: assert (!(go_yng && old_wr && yng_wr && old_dst != '0 && yng_dst == old_dst))
        else $error("pair granted across WAW");
      p_load_use_r6: assert (!(go_old && ex_is_load && ex_dst != '0 &&
                               (old_src_a == ex_dst || old_src_b == ex_dst)))
        else $error("older granted under load-use");
      p_yng_load_use_r7: assert (!(go_yng && ex_is_load && ex_dst != '0 &&
                                   (yng_src_a == ex_dst || yng_src_b == ex_dst)))
        else $error("younger granted under load-use");
      p_empty_slot_r9: assert ((old_valid || (!go_old && !go_yng)) && (yng_valid || !go_yng))
        else $error("grant on empty slot");
      p_stall_def_r10: assert (stall == (old_valid && !go_old))
        else $error("stall inconsistent with grant");
    end
  end
endmodule

bind dual_issue_pair_gate dip_gate_chk #(.REG_W(REG_W)) u_dip_chk (
  .old_valid(old_valid), .old_cls(old_cls), .old_src_a(old_src_a), .old_src_b(old_src_b),
  .old_dst(old_dst), .old_wr(old_wr), .yng_valid(yng_valid), .yng_cls(yng_cls),
  .yng_src_a(yng_src_a), .yng_src_b(yng_src_b), .yng_dst(yng_dst), .yng_wr(yng_wr),
  .ex_dst(ex_dst), .ex_is_load(ex_is_load), .go_old(go_old), .go_yng(go_yng), .stall(stall)
);

// File: tb/dual_issue_pair_gate_tb_top.sv
module dual_issue_pair_gate_tb_top;
  localparam int RW = 5;

  typedef struct packed {
    logic          v;
    logic [1:0]    c;
    logic [RW-1:0] a;
    logic [RW-1:0] b;
    logic [RW-1:0] d;
    logic          w;
  } ins_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          old_valid, old_wr, yng_valid, yng_wr, ex_is_load;
  logic [1:0]    old_cls, yng_cls;
  logic [RW-1:0] old_src_a, old_src_b, old_dst, yng_src_a, yng_src_b, yng_dst, ex_dst;
  logic          go_old, go_yng, stall;

  dual_issue_pair_gate #(.REG_W(RW)) dut_i (
    .old_valid(old_valid), .old_cls(old_cls), .old_src_a(old_src_a), .old_src_b(old_src_b),
    .old_dst(old_dst), .old_wr(old_wr), .yng_valid(yng_valid), .yng_cls(yng_cls),
    .yng_src_a(yng_src_a), .yng_src_b(yng_src_b), .yng_dst(yng_dst), .yng_wr(yng_wr),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load), .go_old(go_old), .go_yng(go_yng), .stall(stall)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic ins_t mk(input int c, input int a, input int b, input int d, input int w);
    ins_t t;
    t.v = 1'b1; t.c = 2'(c); t.a = RW'(a); t.b = RW'(b); t.d = RW'(d); t.w = 1'(w);
    return t;
  endfunction

  // behavioural reference: returns {go_old, go_yng, stall}
  function automatic logic [2:0] ref_decide(input ins_t o, input ins_t y, input int exd, input bit exl);
    bit og, yg;
    og = o.v;
    if (exl && exd != 0 && (int'(o.a) == exd || int'(o.b) == exd)) og = 0;
    yg = og && y.v && (o.c == 2'b01 || o.c == 2'b10) && y.c == 2'b00;
    if (o.w && o.d != 0 && (y.a == o.d || y.b == o.d)) yg = 0;
    if (o.w && y.w && o.d != 0 && y.d == o.d) yg = 0;
    if (exl && exd != 0 && (int'(y.a) == exd || int'(y.b) == exd)) yg = 0;
    return {og, yg, o.v && !og};
  endfunction

  task automatic apply(input ins_t o, input ins_t y, input int exd, input bit exl);
    old_valid = o.v; old_cls = o.c; old_src_a = o.a; old_src_b = o.b; old_dst = o.d; old_wr = o.w;
    yng_valid = y.v; yng_cls = y.c; yng_src_a = y.a; yng_src_b = y.b; yng_dst = y.d; yng_wr = y.w;
    ex_dst = RW'(exd); ex_is_load = exl;
  endtask

  task automatic compare(input string tag, input logic [2:0] exp);
    checks++;
    if ({go_old, go_yng, stall} !== exp) begin
      fails++;
      $display("FAIL %s actual go_old/go_yng/stall=%b expected=%b", tag, {go_old, go_yng, stall}, exp);
    end
  endtask

  task automatic directed(input string tag, input ins_t o, input ins_t y,
                          input int exd, input bit exl, input logic [2:0] exp);
    @(posedge clk); #1;
    apply(o, y, exd, exl);
    @(negedge clk);
    compare(tag, exp);
  endtask

  // replay: returns start cycle of each instruction
  task automatic replay(input string tag, input ins_t seq[$], output int starts[$]);
    int p = 0, cyc = 0, exd = 0;
    bit exl = 0;
    ins_t none = '0;
    starts = {};
    foreach (seq[i]) starts.push_back(-1);
    while (p < seq.size() && cyc < 100) begin
      ins_t o = seq[p];
      ins_t y = (p + 1 < seq.size()) ? seq[p+1] : none;
      logic [2:0] e;
      @(posedge clk); #1;
      apply(o, y, exd, exl);
      e = ref_decide(o, y, exd, exl);
      @(negedge clk);
      compare(tag, e);
      if (e[2]) begin
        starts[p] = cyc;
        exd = int'(o.d); exl = (o.c == 2'b01) && o.w;
        if (e[1]) begin starts[p+1] = cyc; p += 2; end
        else p += 1;
      end else begin
        exd = 0; exl = 0;
      end
      cyc++;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    ins_t nil = '0;
    ins_t ld6 = mk(1, 2, 0, 6, 1);
    ins_t q[$];
    int st[$];
    int exp_a[4] = '{0, 2, 3, 3};
    apply(nil, nil, 0, 0);

    // R9 reset-like idle: nothing valid
    directed("R9 idle", nil, nil, 0, 0, 3'b000);
    directed("R11 independent pair", ld6, mk(0, 4, 5, 7, 1), 0, 0, 3'b110);
    directed("R3 raw on src a", ld6, mk(0, 6, 5, 7, 1), 0, 0, 3'b100);
    directed("R3 raw on src b", ld6, mk(0, 4, 6, 7, 1), 0, 0, 3'b100);
    directed("R4 waw", ld6, mk(0, 4, 5, 6, 1), 0, 0, 3'b100);
    directed("R5 zero dst and src", mk(1, 2, 0, 0, 1), mk(0, 0, 0, 0, 1), 0, 0, 3'b110);
    directed("R5 store no write", mk(2, 6, 5, 6, 0), mk(0, 6, 1, 3, 1), 0, 0, 3'b110);
    directed("R2 alu then alu", mk(0, 1, 2, 3, 1), mk(0, 4, 5, 7, 1), 0, 0, 3'b100);
    directed("R2 load then load", ld6, mk(1, 4, 0, 7, 1), 0, 0, 3'b100);
    directed("R8 other then alu", mk(3, 2, 6, 0, 0), mk(0, 4, 5, 7, 1), 0, 0, 3'b100);
    directed("R6 load-use on older", mk(2, 1, 3, 0, 0), mk(0, 4, 5, 7, 1), 3, 1, 3'b001);
    directed("R10 stall only with valid older", mk(0, 3, 3, 4, 1), nil, 3, 1, 3'b001);
    directed("R6 ex not load", mk(2, 1, 3, 0, 0), mk(0, 4, 5, 7, 1), 3, 0, 3'b110);
    directed("R5 ex load to r0", mk(2, 0, 0, 0, 0), mk(0, 4, 5, 7, 1), 0, 1, 3'b110);
    directed("R7 younger load-use", ld6, mk(0, 9, 5, 7, 1), 9, 1, 3'b100);
    directed("R9 younger invalid", ld6, nil, 0, 0, 3'b100);
    directed("R9 older invalid", nil, mk(0, 4, 5, 7, 1), 0, 0, 3'b000);

    // R11 / R6 replay with hand-computed start cycles
    q = {mk(1, 2, 0, 6, 1), mk(0, 6, 4, 5, 1), mk(1, 5, 0, 7, 1), mk(0, 12, 5, 9, 1)};
    replay("R11 replay A", q, st);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (st[i] != exp_a[i]) begin
        fails++;
        $display("FAIL R6 start cycle of #%0d actual=%0d expected=%0d", i, st[i], exp_a[i]);
      end
    end

    // R1 / R8 mixed replay against the reference each cycle
    q = {mk(2, 6, 5, 0, 0), mk(0, 9, 9, 3, 1), mk(0, 7, 0, 11, 1), mk(3, 2, 6, 0, 0),
         mk(1, 3, 0, 1, 1), mk(0, 1, 1, 2, 1), mk(1, 4, 0, 8, 1), mk(0, 2, 3, 8, 1),
         mk(2, 8, 1, 0, 0), mk(0, 0, 0, 0, 1), mk(1, 0, 0, 0, 1), mk(0, 0, 4, 5, 1)};
    replay("R1 replay B", q, st);
    foreach (st[i]) begin
      checks++;
      if (st[i] < 0 || (i > 0 && st[i] < st[i-1])) begin
        fails++;
        $display("FAIL R1 order of #%0d actual=%0d expected>=prev", i, st[i]);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule